// File: doc/BRIEF.md
# Writeback Slot Reservation Table

Each execution lane has one result path that all of its functional units share. Those units finish after different numbers of cycles. This block treats each lane's result path as a resource that is booked at issue time. It keeps, for every lane, a row of bits that records which future cycles already have a result arriving on that lane. When a lane presents an issue request with latency L, the block looks at the bit for the cycle L ahead. If that bit is clear, the block grants the issue in the same cycle and sets the bit. If it is set, the block withholds the grant. The grant is withheld even when the instruction was picked by selection.

Every row moves one position closer each clock, so reservations age out on their own. The lookup is a direct bit test plus a bit write. There is no second arbiter. A short-latency instruction can be refused because an older, longer-latency instruction already holds its slot, and that lost issue slot is accepted. A flush input drops every booking at once.

Top module: `wb_slot_reserve`

## Requirements
- R1: After reset no slot is booked, so a request on any lane with any latency from 1 to MAX_LAT is granted.
- R2: The grant is combinational in the request cycle. A request on lane l with latency L (1..MAX_LAT) in cycle t is granted exactly when no earlier grant on lane l targets cycle t+L and flush is low. A request with latency MAX_LAT is always granted when flush is low.
- R3: A granted request of latency L in cycle t books cycle t+L on its lane. A later request on that lane whose latency points at t+L is refused. This holds when the later request has a shorter latency, for example latency 2 followed one cycle later by latency 1.
- R4: Requests of equal latency on one lane in consecutive cycles never collide, and all of them are granted.
- R5: A latency value of 0 or above MAX_LAT is refused and books nothing.
- R6: Lanes are independent. A booking on one lane never refuses a request on another lane.
- R7: While flush is high, all requests are refused and every booking is cleared. In the next cycle every in-range request is granted.
- R8: A booking expires once its target cycle is reached. After that the same lane may book that position again.
- R9: A lane with its request low has its grant low.
- R10: Field encoding: lane l's latency sits at bits [l*LAT_W +: LAT_W] of the latency bus. Lane l's request and grant are bit l of their buses. The latency value is the number of cycles from issue to result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| flush_i | input | 1 | Drops all bookings and refuses this cycle's requests |
| req_valid_i | input | NUM_LANES | Issue request per lane |
| req_lat_i | input | NUM_LANES*LAT_W | Requested latency per lane |
| grant_o | output | NUM_LANES | Issue allowed per lane, same cycle |

## Verification
The hardest state to reach is a lane that holds several overlapping bookings of different ages at once, so that a new short-latency request lands exactly on a slot booked by an older long-latency one. Random stimulus alone rarely builds such a chain. Directed sequences therefore issue latency 3, then 2, then 1 on consecutive cycles, as well as equal-latency streams. Long random runs with a mix of latencies and rare flushes then cross those states with flush and expiry.

// File: rtl/wbrt_pkg.sv
package wbrt_pkg;
  localparam int unsigned DEF_LANES   = 4;
  localparam int unsigned DEF_MAX_LAT = 4;

  // width able to carry 0..max_lat+1 so out-of-range codes are representable
  function automatic int unsigned lat_width(input int unsigned max_lat);
    return $clog2(max_lat + 2);
  endfunction
endpackage

// File: rtl/wb_lat_onehot.sv
module wb_lat_onehot #(
  parameter int unsigned MAX_LAT = 4,
  parameter int unsigned LAT_W   = 3
) (
  input  logic [LAT_W-1:0]   lat_i,
  output logic [MAX_LAT-1:0] onehot_o,
  output logic               in_range_o
);
  // bit k set when the latency equals k+1
  for (genvar k = 0; k < MAX_LAT; k++) begin : g_dec
    assign onehot_o[k] = (lat_i == LAT_W'(k + 1));
  end
  assign in_range_o = |onehot_o;

  always_comb begin
    assert_onehot_R5: assert ($onehot0(onehot_o));
  end
endmodule

// File: rtl/wb_lane_table.sv
module wb_lane_table #(
  parameter int unsigned MAX_LAT = 4,
  parameter int unsigned LAT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             req_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             gnt_o
);
  // occ_q[i] : result path busy i+1 cycles ahead; latency MAX_LAT can never be held
  localparam int unsigned DEPTH = MAX_LAT - 1;

  logic [MAX_LAT-1:0] lat_oh;
  logic               lat_ok;
  logic [DEPTH-1:0]   occ_q, occ_d, occ_shift, occ_new;
  logic [MAX_LAT-1:0] occ_view;
  logic               slot_busy;
  logic               occ_en;

  wb_lat_onehot #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_dec (
    .lat_i      (lat_i),
    .onehot_o   (lat_oh),
    .in_range_o (lat_ok)
  );

  assign occ_view  = {1'b0, occ_q};
  assign slot_busy = |(lat_oh & occ_view);
  assign gnt_o     = req_i & lat_ok & ~flush_i & ~slot_busy;

  // a booking for latency L lands at index L-2 after this edge's advance
  assign occ_new = lat_oh[MAX_LAT-1:1] & {DEPTH{gnt_o}};

  if (DEPTH > 1) begin : g_shift
    assign occ_shift = {1'b0, occ_q[DEPTH-1:1]};
  end else begin : g_noshift
    assign occ_shift = '0;
  end

  always_comb begin
    occ_en = flush_i | (|occ_q) | gnt_o;
    if (flush_i) occ_d = '0;
    else         occ_d = occ_shift | occ_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ_q <= '0;
    else if (occ_en) occ_q <= occ_d;
  end

  // R9: no grant without a request
  assert_grant_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |-> !gnt_o);
  // R2: the furthest latency is never held
  assert_max_lat_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !flush_i && lat_i == LAT_W'(MAX_LAT)) |-> gnt_o);
  // R3: a booked slot refuses the request that points at it
  assert_busy_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && lat_i >= LAT_W'(1) && lat_i <= LAT_W'(MAX_LAT)
     && occ_view[int'(lat_i) - 1]) |-> !gnt_o);
  // R3: a grant leaves its slot booked one cycle closer
  assert_booking_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o && lat_i >= LAT_W'(2)) |=> occ_q[int'($past(lat_i)) - 2]);
  // R7: flush refuses and clears
  assert_flush_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> !gnt_o);
  assert_flush_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (occ_q == '0));
  // R5: out-of-range latency is refused
  assert_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_i == '0 || lat_i > LAT_W'(MAX_LAT)) |-> !gnt_o);
  // R8: bookings move one step closer each cycle, none lost
  if (DEPTH > 1) begin : g_adv_chk
    assert_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !flush_i |=> ((occ_q[DEPTH-2:0] & $past(occ_q[DEPTH-1:1])) == $past(occ_q[DEPTH-1:1])));
  end
endmodule

// File: rtl/wb_slot_reserve.sv
module wb_slot_reserve #(
  parameter int unsigned NUM_LANES = wbrt_pkg::DEF_LANES,
  parameter int unsigned MAX_LAT   = wbrt_pkg::DEF_MAX_LAT,
  parameter int unsigned LAT_W     = wbrt_pkg::lat_width(MAX_LAT)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush_i,
  input  logic [NUM_LANES-1:0]       req_valid_i,
  input  logic [NUM_LANES*LAT_W-1:0] req_lat_i,
  output logic [NUM_LANES-1:0]       grant_o
);
  // R10: lane l latency at [l*LAT_W +: LAT_W]; R6: one independent table per lane
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    wb_lane_table #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_tab (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (flush_i),
      .req_i   (req_valid_i[l]),
      .lat_i   (req_lat_i[l*LAT_W +: LAT_W]),
      .gnt_o   (grant_o[l])
    );
  end

  assert_no_stray_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o & ~req_valid_i) == '0));
endmodule

// File: tb/tb_wb_slot_reserve.sv
module tb_wb_slot_reserve;
  localparam int NL = 4;
  localparam int ML = 4;
  localparam int LW = 3;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush;
  logic [NL-1:0] req_v;
  logic [NL*LW-1:0] req_lat;
  logic [NL-1:0] grant;

  int compared = 0, mismatched = 0, cyc = 0;
  bit done = 0;
  logic [ML:0] mb [NL];   // bit d : lane busy d cycles ahead

  wb_slot_reserve #(.NUM_LANES(NL), .MAX_LAT(ML), .LAT_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .req_valid_i(req_v),
    .req_lat_i(req_lat), .grant_o(grant));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      mismatched++;
      $display("FAIL watchdog: actual cycles=%0d expected <=%0d", cyc, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic bit exp_grant(input logic [ML:0] busy, input bit v,
                                   input int lat, input bit fl);
    return v && lat >= 1 && lat <= ML && !fl && !busy[lat];
  endfunction

  function automatic logic [NL*LW-1:0] pack(input int a, input int b,
                                            input int c, input int d);
    logic [NL*LW-1:0] r;
    r = {LW'(d), LW'(c), LW'(b), LW'(a)};
    return r;
  endfunction

  function automatic string auto_tag(input bit v, input int lat, input bit fl);
    if (fl) return "R7";
    if (!v) return "R9";
    if (lat < 1 || lat > ML) return "R5";
    return "R2";
  endfunction

  task automatic model_clear();
    for (int l = 0; l < NL; l++) mb[l] = '0;
  endtask

  task automatic cycle(input bit fl, input logic [NL-1:0] v,
                       input logic [NL*LW-1:0] lats, input string tag);
    @(negedge clk);
    flush = fl; req_v = v; req_lat = lats;
    #1;
    for (int l = 0; l < NL; l++) begin
      int  lat;
      bit  e;
      string t;
      lat = int'(lats[l*LW +: LW]);
      e = exp_grant(mb[l], v[l], lat, fl);
      t = (tag == "") ? auto_tag(v[l], lat, fl) : tag;
      compared++;
      if (grant[l] !== e) begin
        mismatched++;
        $display("FAIL %s lane %0d lat %0d: actual grant=%b expected=%b", t, l, lat, grant[l], e);
      end
      if (fl) mb[l] = '0;
      else begin
        if (e) mb[l][lat] = 1'b1;
        mb[l] = mb[l] >> 1;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; flush = 0; req_v = '0; req_lat = '0;
    @(negedge clk);
    model_clear();
    rst_n = 1'b1;
  endtask

  initial begin
    flush = 0; req_v = '0; req_lat = '0;
    model_clear();
    do_reset();
    // R1: reset state, every lane and latency free
    cycle(0, 4'b1111, pack(1, 2, 3, 4), "R1");
    cycle(0, 4'b0000, '0, "R9");
    cycle(0, 4'b0000, '0, "R9");
    cycle(0, 4'b0000, '0, "R9");
    // R3: latency 2 then latency 1 on the same slot
    cycle(0, 4'b0001, pack(2, 0, 0, 0), "R3");
    cycle(0, 4'b0001, pack(1, 0, 0, 0), "R3");
    // R3: latency 3 blocks later shorter ones aimed at the same cycle
    cycle(0, 4'b0001, pack(3, 0, 0, 0), "R3");
    cycle(0, 4'b0001, pack(2, 0, 0, 0), "R3");
    cycle(0, 4'b0001, pack(1, 0, 0, 0), "R3");
    // R8: after expiry the slot is free again
    cycle(0, 4'b0000, '0, "R8");
    cycle(0, 4'b0001, pack(1, 0, 0, 0), "R8");
    // R4: equal latency back to back
    for (int i = 0; i < 5; i++) cycle(0, 4'b1111, pack(2, 2, 3, 3), "R4");
    for (int i = 0; i < 4; i++) cycle(0, 4'b0000, '0, "R9");
    // R6: booking on lane 0 leaves lane 1 free
    cycle(0, 4'b0001, pack(3, 0, 0, 0), "R6");
    cycle(0, 4'b0011, pack(2, 2, 0, 0), "R6");
    // R5: out-of-range codes refused, nothing booked
    cycle(0, 4'b1111, pack(0, 5, 6, 7), "R5");
    cycle(0, 4'b1111, pack(1, 4, 3, 2), "R5");
    // R7: flush refuses and clears bookings
    cycle(0, 4'b0001, pack(3, 0, 0, 0), "R7");
    cycle(1, 4'b1111, pack(2, 2, 2, 2), "R7");
    cycle(0, 4'b1111, pack(1, 1, 1, 1), "R7");
    // random phase
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      logic [NL-1:0] v;
      logic [NL*LW-1:0] lt;
      bit fl;
      v = NL'($urandom);
      for (int l = 0; l < NL; l++) begin
        int r;
        r = int'($urandom_range(0, 19));
        lt[l*LW +: LW] = (r == 0) ? LW'(0) : (r == 1) ? LW'(ML + 1) : LW'(1 + (r % ML));
      end
      fl = ($urandom_range(0, 49) == 0);
      cycle(fl, v, lt, "");
    end
    // R1: reset in the middle of traffic clears bookings
    cycle(0, 4'b1111, pack(4, 4, 4, 4), "");
    cycle(0, 4'b1111, pack(3, 3, 3, 3), "");
    do_reset();
    cycle(0, 4'b1111, pack(2, 2, 1, 1), "R1");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule